// File: doc/BRIEF.md
# Host-Programmed 16-bit Down-Counter / Timer

This block is a 16-bit down-counter that a host programs and observes through a small byte-wide register port. It serves a pair of serial channels. The starting value comes from two host-written byte registers, one for the high half and one for the low half. The block runs in one of two modes, chosen by a mode bit.

In timer mode the counter runs without a stop. It counts the reference clock down from the starting value, reloads, and toggles a square-wave output on each reload. That output can feed a channel's clock selector as a 16X clock for a baud rate that the fixed generator does not offer. In counter mode the host starts the count by reading one address and halts it by reading another. The counter decrements once per clock and raises a ready flag each time it passes through zero. The live count can be read back as two bytes, and the two halves always come from the same snapshot.

Top module: `ctmr_top`

## Requirements
- R1: After reset, `bus_rdata`, `wave_out` and `ready_irq` are 0, the count reads 0, and the block is in counter mode and not started.
- R2: A write to address 0 sets the preset high byte and a write to address 1 sets the preset low byte. A write to address 2 sets the mode from data bit 0 (1 = timer, 0 = counter). Reads of addresses 0, 1 and 2 return these registers, with the mode in bit 0.
- R3: A read of address 5 loads the count with the effective preset and marks the counter as started. In counter mode the count then drops by one on each following clock.
- R4: In counter mode, a started count that is 0 sets the ready flag (`ready_irq`) on the next clock, wraps to 0xFFFF and keeps counting.
- R5: A read of address 6 always clears the ready flag. In counter mode it also clears the started state and holds the count at its current value.
- R6: In timer mode the count runs from the effective preset P down to 1. On the clock after it reaches 1 it reloads P, toggles `wave_out` and sets the ready flag, so `wave_out` has a period of 2P clocks.
- R7: A programmed preset below 2 is used as 2 wherever the preset is loaded.
- R8: A read of address 3 returns the count's high byte and captures its low byte from the same cycle. A read of address 4 returns the captured low byte.
- R9: A write to address 2 reloads the count with the effective preset and clears the started state, the ready flag and `wave_out`.
- R10: Read data is registered and appears on the clock after the read strobe. Address 7 returns {5'b0, wave, started, ready}. Reads of addresses 5 and 6 return 0. Reads of other addresses do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| wave_out | output | 1 | Square-wave output in timer mode |
| ready_irq | output | 1 | Ready / interrupt flag |

## Verification
The hardest case to reach from the ports is the wrap through zero in counter mode combined with a stop read or a mode write in the same cycle as a reload or a terminal count. The stimulus reaches it by keeping preset values small, mostly below 20, and by starting, stopping, switching mode and reading back at random intervals. Collisions of this kind then happen often. A cycle-accurate model in the bench, written from the requirements, predicts every read byte and the two output flags on every cycle.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PRE_HI = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRE_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_START  = 3'd5;
  localparam logic [ADDR_W-1:0] A_STOP   = 3'd6;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd7;

  typedef struct packed {
    logic start;
    logic stop;
    logic mode_wr;
  } ctmr_strb_t;
endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
  import ctmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     pre_hi,
  output logic [DW-1:0]     pre_lo,
  output logic              mode_timer,
  output ctmr_strb_t        strb
);
  always_comb begin
    strb.start   = rd && (addr == A_START);
    strb.stop    = rd && (addr == A_STOP);
    strb.mode_wr = wr && (addr == A_MODE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_hi     <= '0;
      pre_lo     <= '0;
      mode_timer <= 1'b0;
    end else if (wr) begin
      if (addr == A_PRE_HI) pre_hi <= wdata;
      if (addr == A_PRE_LO) pre_lo <= wdata;
      if (addr == A_MODE)   mode_timer <= wdata[0];
    end
  end

  // R2
  mode_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_MODE) |=> mode_timer == $past(wdata[0]));
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
#(
  parameter int DW         = 8,
  parameter int MIN_PRESET = 2,
  localparam int CW        = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pre_hi,
  input  logic [DW-1:0] pre_lo,
  input  logic          mode_timer,
  input  ctmr_strb_t    strb,
  output logic [CW-1:0] cnt,
  output logic          run,
  output logic          rdy,
  output logic          wave
);
  logic [CW-1:0] raw_pre, eff_pre;
  logic          tick;

  always_comb begin
    raw_pre = {pre_hi, pre_lo};
    eff_pre = (raw_pre < CW'(MIN_PRESET)) ? CW'(MIN_PRESET) : raw_pre;
    tick    = mode_timer ? 1'b1 : (run && !strb.stop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      run  <= 1'b0;
      rdy  <= 1'b0;
      wave <= 1'b0;
    end else if (strb.mode_wr) begin
      cnt  <= eff_pre;
      run  <= 1'b0;
      rdy  <= 1'b0;
      wave <= 1'b0;
    end else begin
      if (strb.start) begin
        cnt <= eff_pre;
        run <= 1'b1;
      end else if (tick) begin
        if (mode_timer) begin
          if (cnt <= CW'(1)) begin
            cnt  <= eff_pre;
            wave <= ~wave;
            if (!strb.stop) rdy <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
          if (cnt == '0 && !strb.stop) rdy <= 1'b1;
        end
      end
      if (strb.stop) begin
        rdy <= 1'b0;
        if (!mode_timer) run <= 1'b0;
      end
    end
  end

  // R5
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    strb.stop |=> !rdy);
  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.stop && !mode_timer && !strb.mode_wr) |=> $stable(cnt));
  // R7
  timer_floor_chk: assert property (@(posedge clk) disable iff (rst)
    mode_timer |-> cnt != '0);
  // R6
  wave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_timer && !strb.mode_wr) |=> $stable(wave));
  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.start && !strb.mode_wr) |=> cnt >= CW'(MIN_PRESET));
endmodule

// File: rtl/ctmr_readback.sv
module ctmr_readback
  import ctmr_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     pre_hi,
  input  logic [DW-1:0]     pre_lo,
  input  logic              mode_timer,
  input  logic [CW-1:0]     cnt,
  input  logic              run,
  input  logic              rdy,
  input  logic              wave,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] lo_snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      lo_snap <= '0;
    end else if (rd) begin
      unique case (addr)
        A_PRE_HI: rdata <= pre_hi;
        A_PRE_LO: rdata <= pre_lo;
        A_MODE:   rdata <= DW'(mode_timer);
        A_CNT_HI: begin
          rdata   <= cnt[CW-1:DW];
          lo_snap <= cnt[DW-1:0];
        end
        A_CNT_LO: rdata <= lo_snap;
        A_STAT:   rdata <= DW'({wave, run, rdy});
        default:  rdata <= '0;
      endcase
    end
  end

  // R8
  hi_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == A_CNT_HI) |=> rdata == $past(cnt[CW-1:DW]));
  // R8
  snap_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == A_CNT_HI) |=> lo_snap == $past(cnt[DW-1:0]));
  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int DW         = 8,
  parameter int MIN_PRESET = 2,
  localparam int CW        = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              wave_out,
  output logic              ready_irq
);
  logic [DW-1:0] pre_hi, pre_lo;
  logic          mode_timer, run, rdy, wave;
  logic [CW-1:0] cnt;
  ctmr_strb_t    strb;

  ctmr_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .pre_hi(pre_hi), .pre_lo(pre_lo),
    .mode_timer(mode_timer), .strb(strb)
  );

  ctmr_core #(.DW(DW), .MIN_PRESET(MIN_PRESET)) u_core (
    .clk(clk), .rst(rst), .pre_hi(pre_hi), .pre_lo(pre_lo),
    .mode_timer(mode_timer), .strb(strb), .cnt(cnt), .run(run),
    .rdy(rdy), .wave(wave)
  );

  ctmr_readback #(.DW(DW)) u_rb (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr), .pre_hi(pre_hi),
    .pre_lo(pre_lo), .mode_timer(mode_timer), .cnt(cnt), .run(run),
    .rdy(rdy), .wave(wave), .rdata(bus_rdata)
  );

  assign wave_out  = wave;
  assign ready_irq = rdy;
endmodule

// File: tb/tb_ctmr_top.sv
module tb_ctmr_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       wave_out, ready_irq;

  int n_chk = 0, n_bad = 0;
  bit flag_chk = 1'b0;

  always #2 clk = ~clk;

  ctmr_top dut (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wave_out(wave_out), .ready_irq(ready_irq));

  // reference model built from the requirements
  logic [15:0] m_cnt, m_eff;
  logic [7:0]  m_hi, m_lo, m_snap, m_rdata;
  logic        m_mode, m_run, m_rdy, m_wave;

  always @(posedge clk) begin
    m_eff = ({m_hi, m_lo} < 16'd2) ? 16'd2 : {m_hi, m_lo}; // R7
    if (rst) begin
      m_cnt <= 0; m_hi <= 0; m_lo <= 0; m_snap <= 0; m_rdata <= 0;
      m_mode <= 0; m_run <= 0; m_rdy <= 0; m_wave <= 0;
    end else begin
      if (bus_rd) begin
        case (bus_addr)
          3'd0: m_rdata <= m_hi;
          3'd1: m_rdata <= m_lo;
          3'd2: m_rdata <= {7'd0, m_mode};
          3'd3: begin m_rdata <= m_cnt[15:8]; m_snap <= m_cnt[7:0]; end
          3'd4: m_rdata <= m_snap;
          3'd7: m_rdata <= {5'd0, m_wave, m_run, m_rdy};
          default: m_rdata <= 8'd0;
        endcase
      end
      if (bus_wr && bus_addr == 3'd0) m_hi <= bus_wdata;
      if (bus_wr && bus_addr == 3'd1) m_lo <= bus_wdata;
      if (bus_wr && bus_addr == 3'd2) begin // R9
        m_mode <= bus_wdata[0]; m_cnt <= m_eff;
        m_run <= 0; m_rdy <= 0; m_wave <= 0;
      end else if (bus_rd && bus_addr == 3'd5) begin // R3
        m_cnt <= m_eff; m_run <= 1;
      end else begin
        if (bus_rd && bus_addr == 3'd6) begin // R5
          m_rdy <= 0;
          if (!m_mode) m_run <= 0;
        end
        if (m_mode) begin // R6
          if (m_cnt <= 16'd1) begin
            m_cnt <= m_eff; m_wave <= ~m_wave;
            if (!(bus_rd && bus_addr == 3'd6)) m_rdy <= 1;
          end else m_cnt <= m_cnt - 16'd1;
        end else if (m_run && !(bus_rd && bus_addr == 3'd6)) begin // R4
          m_cnt <= m_cnt - 16'd1;
          if (m_cnt == 16'd0) m_rdy <= 1;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (flag_chk) begin
    check("R6 wave_out", wave_out, m_wave);
    check("R4 ready_irq", ready_irq, m_rdy);
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a);
    string req;
    bus_addr = a; bus_rd = 1;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
    case (a)
      3'd0, 3'd1, 3'd2: req = "R2 read";
      3'd3, 3'd4: req = "R8 count read";
      default: req = "R10 read";
    endcase
    check(req, bus_rdata, m_rdata);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_count();
    rd_reg(3'd3); rd_reg(3'd4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    check("R1 rdata", bus_rdata, 0);
    check("R1 wave", wave_out, 0);
    check("R1 irq", ready_irq, 0);
    flag_chk = 1'b1;
    read_count();
    rd_reg(3'd7);
    // R2 / R3 / R5: counter mode, preset 5, stop after 3 idle cycles
    wr_reg(3'd0, 8'h00); wr_reg(3'd1, 8'h05);
    rd_reg(3'd0); rd_reg(3'd1); rd_reg(3'd2);
    rd_reg(3'd5); idle(3); rd_reg(3'd6);
    read_count();
    check("R5 held count", {8'h00, bus_rdata}, 16'd2);
    // R4: wrap through zero
    rd_reg(3'd5); idle(8); rd_reg(3'd7); read_count(); rd_reg(3'd6); rd_reg(3'd7);
    // R7 / R6: timer with preset 0, then preset 3
    wr_reg(3'd1, 8'h00); wr_reg(3'd2, 8'h01); idle(12); rd_reg(3'd7);
    wr_reg(3'd1, 8'h03); rd_reg(3'd5); idle(20); rd_reg(3'd6); read_count();
    // R9: leave timer mode mid-count
    idle(2); wr_reg(3'd2, 8'h00); rd_reg(3'd7); read_count();
    // R8: multi-byte preset
    wr_reg(3'd0, 8'h01); wr_reg(3'd1, 8'h02); rd_reg(3'd5); idle(5); read_count();
    rd_reg(3'd6);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: wr_reg(3'd0, ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h00);
        1: wr_reg(3'd1, 8'($urandom_range(0, 18)));
        2: wr_reg(3'd2, 8'($urandom_range(0, 1)));
        3: rd_reg(3'd5);
        4: rd_reg(3'd6);
        5: read_count();
        6: rd_reg(3'($urandom_range(0, 7)));
        default: idle($urandom_range(0, 25));
      endcase
    end
    flag_chk = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule